// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a synchronous binary up-counter of parameterised width (four bits by default). A rising clock edge updates all of its register bits together, so every output bit changes in the same instant. A parallel data word can be preset into the register on a clock edge. An active-low clear zeroes the register at once, without waiting for an edge.

There are two count enables. The general enable only gates counting. The chain enable gates counting and also the carry output. The carry output is high while the chain enable is high and the count holds its all-ones value. To build a wider counter, feed each stage's carry into the chain enable of the next stage, and share the clock, the clear, the load and the general enable across all stages. This takes no added gates between stages.

Top module: `pcnt_stage`

## Requirements
- R1: While `clr_n_i` is low, `count_o` is zero at once, with no clock edge needed, whatever the levels of the load, the enables and the data.
- R2: If `ld_n_i` is low at a rising clock edge, `count_o` takes the value of `preset_i` on that edge, whatever the levels of both enables. Any value from 0 to 2^WIDTH-1 can be loaded.
- R3: If `ld_n_i`, `cnt_en_i` and `carry_en_i` are all high at a rising edge, `count_o` increases by one.
- R4: If `ld_n_i` is high and either enable is low at a rising edge, `count_o` keeps its value. A change on an enable or on the load between edges leaves `count_o` unchanged.
- R5: An enabled count from the all-ones value (15 for WIDTH=4) wraps `count_o` to zero.
- R6: `carry_o` is high exactly when `carry_en_i` is high and `count_o` is all ones. It follows changes on `carry_en_i` without waiting for a clock edge.
- R7: With `cnt_en_i` low and `carry_en_i` high, the count holds and `carry_o` still reports the all-ones state.
- R8: Two stages chained through `carry_o` into the upper stage's `carry_en_i` form an 8-bit counter that runs from 0 to 255 and wraps to 0.
- R9: Clear takes priority over load: if `clr_n_i` and `ld_n_i` are both low across an edge, `count_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| clr_n_i | input | 1 | Asynchronous clear, active low |
| ld_n_i | input | 1 | Synchronous preset strobe, active low |
| cnt_en_i | input | 1 | General count enable |
| carry_en_i | input | 1 | Chain enable; gates counting and the carry output |
| preset_i | input | WIDTH | Parallel preset value, bit 0 least significant |
| count_o | output | WIDTH | Current count, bit 0 least significant |
| carry_o | output | 1 | Carry to the next stage |

## Verification
On every clock, the bound checker checks the edge-to-edge rules: the preset on load, the single step and the wrap when both enables are on, holding in every other case, the zero under clear, and the carry level against the chain enable and the count. Some behaviour can be seen only in the bench's scenarios, because a clocked property does not sample between edges. These are a clear that arrives between edges, a carry that changes when the chain enable moves between edges, clear winning over a pending load, and the full 0 to 255 run of two chained stages with the carry passing from the lower stage to the upper one.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Operation chosen for the next clock edge (clear is handled asynchronously)
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic     ld_n_i,
  input  logic     cnt_en_i,
  input  logic     carry_en_i,
  output pcnt_op_e op_o
);
  // Priority: load over counting over holding
  always_comb begin
    if (!ld_n_i)                       op_o = OP_LOAD;
    else if (cnt_en_i && carry_en_i)   op_o = OP_INC;
    else                               op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] preset_i,
  input  pcnt_op_e         op_i,
  output logic [WIDTH-1:0] nxt_o
);
  // Look-ahead toggle terms: bit k toggles when all lower bits are one
  logic [WIDTH:0]   all_ones_below;
  logic [WIDTH-1:0] incr;

  assign all_ones_below[0] = 1'b1;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_bit
      assign all_ones_below[k+1] = all_ones_below[k] & cur_i[k];
      assign incr[k]             = cur_i[k] ^ all_ones_below[k];
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_LOAD: nxt_o = preset_i;
      OP_INC:  nxt_o = incr;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             carry_en_i,
  output logic             carry_o
);
  // Purely combinational: follows the chain enable without a clock edge
  assign carry_o = carry_en_i & (&count_i);
endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             clr_n_i,
  input  logic             ld_n_i,
  input  logic             cnt_en_i,
  input  logic             carry_en_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  pcnt_op_e         op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_we;

  pcnt_ctrl u_ctrl (
    .ld_n_i     (ld_n_i),
    .cnt_en_i   (cnt_en_i),
    .carry_en_i (carry_en_i),
    .op_o       (op)
  );

  pcnt_next #(.WIDTH(WIDTH)) u_next (
    .cur_i    (cnt_q),
    .preset_i (preset_i),
    .op_i     (op),
    .nxt_o    (cnt_d)
  );

  // Clock enable written out: register is written only on load or count
  assign cnt_we = (op != OP_HOLD);

  // Clear acts immediately and is not resynchronised, so the first edge
  // after release already counts
  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i)    cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  pcnt_carry #(.WIDTH(WIDTH)) u_carry (
    .count_i    (cnt_q),
    .carry_en_i (carry_en_i),
    .carry_o    (carry_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/pcnt_stage_chk.sv
module pcnt_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             clr_n_i,
  input logic             ld_n_i,
  input logic             cnt_en_i,
  input logic             carry_en_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o
);
  localparam logic [WIDTH-1:0] MAXV = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !clr_n_i |-> count_o == '0); // R1

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    !ld_n_i |=> count_o == $past(preset_i)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (ld_n_i && cnt_en_i && carry_en_i && count_o != MAXV)
      |=> count_o == WIDTH'($past(count_o) + 1'b1)); // R3

  AST_HOLD_VALUE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (ld_n_i && !(cnt_en_i && carry_en_i)) |=> $stable(count_o)); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (ld_n_i && cnt_en_i && carry_en_i && count_o == MAXV) |=> count_o == '0); // R5

  AST_CARRY_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    carry_o |-> (carry_en_i && count_o == MAXV)); // R6

  AST_CARRY_AT_MAX: assert property (@(posedge clk_i) disable iff (!clr_n_i)
    (carry_en_i && !cnt_en_i && count_o == MAXV) |-> carry_o); // R7
endmodule

bind pcnt_stage pcnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .clr_n_i    (clr_n_i),
  .ld_n_i     (ld_n_i),
  .cnt_en_i   (cnt_en_i),
  .carry_en_i (carry_en_i),
  .preset_i   (preset_i),
  .count_o    (count_o),
  .carry_o    (carry_o)
);

// File: tb/pcnt_stage_bench.sv
module pcnt_stage_bench;
  logic       clk = 1'b0;
  logic       clr_n;
  logic       ld_n;
  logic       en_g;
  logic       en_c;
  logic [3:0] pre_lo;
  logic [3:0] pre_hi;
  logic [3:0] cnt_lo;
  logic [3:0] cnt_hi;
  logic       cy_lo;
  logic       cy_hi;

  int n_checks = 0;
  int n_fails  = 0;
  int model    = 0;   // 8-bit reference value of the chained pair
  bit done     = 0;

  always #2 clk = ~clk; // 250 MHz

  pcnt_stage #(.WIDTH(4)) u_pcnt_stage (
    .clk_i(clk), .clr_n_i(clr_n), .ld_n_i(ld_n), .cnt_en_i(en_g),
    .carry_en_i(en_c), .preset_i(pre_lo), .count_o(cnt_lo), .carry_o(cy_lo)
  );

  pcnt_stage #(.WIDTH(4)) u_pcnt_stage_hi (
    .clk_i(clk), .clr_n_i(clr_n), .ld_n_i(ld_n), .cnt_en_i(en_g),
    .carry_en_i(cy_lo), .preset_i(pre_hi), .count_o(cnt_hi), .carry_o(cy_hi)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit lc;
    lc = en_c && (model % 16 == 15);
    check({tag, " low count"},  int'(cnt_lo), model % 16);
    check({tag, " high count"}, int'(cnt_hi), model / 16);
    check({tag, " low carry"},  int'(cy_lo),  int'(lc));
    check({tag, " high carry"}, int'(cy_hi),  int'(lc && (model / 16 == 15)));
  endtask

  // One clock edge: update the reference behaviourally, compare after it
  task automatic step(input string tag);
    @(posedge clk);
    if (!clr_n)             model = 0;
    else if (!ld_n)         model = int'(pre_hi) * 16 + int'(pre_lo);
    else if (en_g && en_c)  model = (model + 1) % 256;
    #1;
    compare(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    clr_n = 1'b0; ld_n = 1'b1; en_g = 1'b1; en_c = 1'b1;
    pre_lo = 4'd0; pre_hi = 4'd0;
    #1;
    compare("R1 reset state");
    step("R1 held in clear");
    step("R1 held in clear");
    clr_n = 1'b1;

    // R3 plain counting, R5 low stage wraps into high stage
    for (int i = 0; i < 20; i++) step("R3 count step");
    check("R5 wrap crossed", int'(cnt_hi), 1);

    // R2 load overrides active enables
    ld_n = 1'b0; pre_lo = 4'd14; pre_hi = 4'd0;
    step("R2 load with enables on");
    ld_n = 1'b1; pre_lo = 4'd3;
    step("R3 count after load");
    step("R5 low stage reaches 0 after 15");

    // R7 / R6: general enable low, chain high, at all ones
    ld_n = 1'b0; pre_lo = 4'd15; pre_hi = 4'd2;
    step("R2 load 15");
    ld_n = 1'b1; en_g = 1'b0;
    step("R7 hold with carry valid");
    check("R7 carry at max with general enable low", int'(cy_lo), 1);
    step("R4 hold");

    // R6: chain enable low suppresses carry, between edges
    en_c = 1'b0; #1;
    check("R6 carry drops without edge", int'(cy_lo), 0);
    en_g = 1'b1;
    step("R4 hold with chain enable low");
    step("R4 hold with chain enable low");
    en_c = 1'b1; #1;
    check("R6 carry rises without edge", int'(cy_lo), 1);
    ld_n = 1'b0; #1;
    check("R4 load change between edges no effect", int'(cnt_lo), 15);
    ld_n = 1'b1;

    // R1 clear mid-cycle
    step("R3 pre-clear count");
    step("R3 pre-clear count");
    clr_n = 1'b0; #1;
    model = 0;
    compare("R1 clear between edges");
    // R9 clear beats pending load
    ld_n = 1'b0; pre_lo = 4'd9; pre_hi = 4'd9;
    step("R9 clear over load");
    clr_n = 1'b1; ld_n = 1'b1;

    // R8 full chained run 0..255 and wrap
    for (int i = 0; i < 258; i++) step("R8 chained count");
    check("R8 chained wrap value", int'(cnt_hi) * 16 + int'(cnt_lo), 2);

    // R2 any preset value, R5 chained wrap from 255
    ld_n = 1'b0; pre_lo = 4'd15; pre_hi = 4'd15;
    step("R2 load 255");
    ld_n = 1'b1;
    step("R5 chained wrap to 0");

    done = 1;
    finish_run();
  end
endmodule